// File: doc/BRIEF.md
# Hibernation power sequencing controller

This block drives a regulator-off output. While the output is high, an external regulator removes the main supply so the chip can hibernate. When a wake-up condition arrives, the block drops the output so that power comes back. The whole block runs from the always-on slow clock, nominally 32.768 kHz, so it keeps working after main power is gone. That clock also drives a seconds counter, built from a prescaler that counts slow ticks.

Software reaches the block over a small register bus that is synchronous to the slow clock. Through it, software can:

- set the seconds counter to a new value;
- program two match values;
- trim the length of a second;
- turn each wake-up source on or off;
- choose whether a low-battery flag stops hibernation from starting.

Writing the request bit starts the sequence. The controller moves through idle, enter, hibernate and wake states. It returns to idle once the main supply is reported good again. A wake-cause register records why the last wake-up happened, or that a request was refused. Software clears its bits by writing 1s to them.

The bus has no flow control. A write takes effect on the clock edge that samples `wr_en`. A read returns its data one cycle later, marked by `rvalid`.

Top module: `hib_ctrl`

## Requirements
- R1: After reset, `pwr_off` is 0, `hibernating` is 0, `sec_count` is 0 and the cause register reads 0.
- R2: Writing address 0 with bit 0 set while idle starts hibernation, unless R3 refuses it. From the next cycle on, `pwr_off` and `hibernating` are both 1.
- R3: Bit 3 of a control write enables the low-battery block. If that bit is set in the request write and `batt_low` is 1, the request is refused. The block stays idle with `pwr_off` at 0, and cause bit 3 is set.
- R4: When control bit 1 is set, a high `wake_pin` during hibernation starts a wake-up. The pin passes through a two-flop synchronizer, so `pwr_off` falls after the third rising edge counted from the pin rising. This wake-up sets cause bit 0. When control bit 1 is clear, the pin has no effect.
- R5: When control bit 2 is set, `sec_count` equal to MATCH0 (address 3) or to MATCH1 (address 4) during hibernation starts a wake-up. It sets cause bit 1 or cause bit 2 respectively.
- R6: After a wake-up, `pwr_off` is 0 and `hibernating` stays 1 for as long as `pwr_good` is 0. On the first edge with `pwr_good` at 1, the block returns to idle.
- R7: The cause register is at address 6, in bits [3:0]. Writing a 1 to a bit clears it. A bit that is being set in the same cycle stays set.
- R8: `sec_count` rises by 1 every TICKS_PER_SEC slow-clock cycles. A write to address 2 loads `sec_count` from `wdata` and restarts the current second and the 64-second trim period.
- R9: Trim is at address 5, in bits [1:0]. The value 01 makes every 64th second one tick longer. The value 11 makes it one tick shorter. Any other value leaves the length unchanged.
- R10: A read whose `rd_en` is sampled on an edge returns `rdata` with `rvalid` after that edge. Address 0 returns the enables in bits [3:1] with bit 0 reading 0, and address 1 returns the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, registered |
| rvalid | output | 1 | Read data valid |
| wake_pin | input | 1 | External wake request, asynchronous |
| batt_low | input | 1 | Low-battery comparator flag |
| pwr_good | input | 1 | Main supply reported good |
| pwr_off | output | 1 | Regulator-off request |
| hibernating | output | 1 | Sequence active (not idle) |
| sec_count | output | CNT_W | Seconds counter |

## Verification
The hardest case to reach is the trim correction, because it only shows on every 64th second. The bench builds the design with eight ticks per second. It loads the counter, which also restarts the 64-second period, and then counts exact cycle offsets around the 512-cycle boundary for each trim setting. Match wake-ups are reached by loading the counter a few seconds below a match value just before the request. The synchronizer delay is measured by raising the pin on a known edge during hibernation.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_HIB   = 2'd2,
    ST_WAKE  = 2'd3
  } hib_state_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] A_LOAD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MAT0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MAT1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TRIM  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CAUSE = 3'd6;

  localparam int N_MATCH = 2;
  localparam int CAUSE_W = 4;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hib_rtc.sv
module hib_rtc #(
  parameter int CNT_W         = 32,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       trim,
  output logic [CNT_W-1:0] count
);
  localparam int PRE_W = $clog2(TICKS_PER_SEC + 1);
  localparam logic [PRE_W-1:0] T_NORM  = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [PRE_W-1:0] T_LONG  = PRE_W'(TICKS_PER_SEC);
  localparam logic [PRE_W-1:0] T_SHORT = PRE_W'(TICKS_PER_SEC - 2);

  logic [PRE_W-1:0] pre;
  logic [5:0]       epoch;
  logic [PRE_W-1:0] terminal;
  logic             wrap;

  always_comb begin
    terminal = T_NORM;
    if (epoch == 6'd63) begin
      if (trim == 2'b01)      terminal = T_LONG;
      else if (trim == 2'b11) terminal = T_SHORT;
    end
  end

  assign wrap = (pre == terminal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      epoch <= '0;
      count <= '0;
    end else if (load) begin
      pre   <= '0;
      epoch <= '0;
      count <= load_val;
    end else if (wrap) begin
      pre   <= '0;
      epoch <= epoch + 6'd1;
      count <= count + CNT_W'(1);
    end else begin
      pre   <= pre + PRE_W'(1);
    end
  end
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wake_evt,
  input  logic       pwr_good,
  output hib_state_e state
);
  hib_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start)    nxt = ST_ENTER;
      ST_ENTER:               nxt = ST_HIB;
      ST_HIB:   if (wake_evt) nxt = ST_WAKE;
      ST_WAKE:  if (pwr_good) nxt = ST_IDLE;
      default:                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int TICKS_PER_SEC = 32768,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             rvalid,
  input  logic             wake_pin,
  input  logic             batt_low,
  input  logic             pwr_good,
  output logic             pwr_off,
  output logic             hibernating,
  output logic [CNT_W-1:0] sec_count
);
  hib_state_e         state;
  logic               en_pin, en_rtc, en_blk;
  logic [CNT_W-1:0]   match_q [N_MATCH];
  logic [1:0]         trim_q;
  logic [CAUSE_W-1:0] cause_q, cause_set, cause_clr;
  logic               wake_s, in_hib, pin_hit, wr_ctrl, req, refuse, start;
  logic [N_MATCH-1:0] m_hit;

  hib_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_pin), .q(wake_s)
  );

  hib_rtc #(.CNT_W(CNT_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_rtc (
    .clk(clk), .rst_n(rst_n),
    .load(wr_en && addr == A_LOAD), .load_val(wdata),
    .trim(trim_q), .count(sec_count)
  );

  assign in_hib  = (state == ST_HIB);
  assign pin_hit = en_pin && wake_s;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign req     = wr_ctrl && wdata[0] && state == ST_IDLE;
  assign refuse  = wdata[3] && batt_low;
  assign start   = req && !refuse;

  generate
    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
      assign m_hit[i] = en_rtc && (sec_count == match_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   match_q[i] <= '0;
        else if (wr_en && addr == A_MAT0 + 3'(i))     match_q[i] <= wdata;
      end
    end
  endgenerate

  hib_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wake_evt(in_hib && (pin_hit || (|m_hit))),
    .pwr_good(pwr_good), .state(state)
  );

  assign cause_set = {req && refuse, m_hit[1] && in_hib, m_hit[0] && in_hib, pin_hit && in_hib};
  assign cause_clr = (wr_en && addr == A_CAUSE) ? wdata[CAUSE_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pin  <= 1'b0;
      en_rtc  <= 1'b0;
      en_blk  <= 1'b0;
      trim_q  <= '0;
      cause_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_pin <= wdata[1];
        en_rtc <= wdata[2];
        en_blk <= wdata[3];
      end
      if (wr_en && addr == A_TRIM) trim_q <= wdata[1:0];
      cause_q <= (cause_q & ~cause_clr) | cause_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= CNT_W'({en_blk, en_rtc, en_pin, 1'b0});
          A_COUNT: rdata <= sec_count;
          A_LOAD:  rdata <= sec_count;
          A_MAT0:  rdata <= match_q[0];
          A_MAT1:  rdata <= match_q[1];
          A_TRIM:  rdata <= CNT_W'(trim_q);
          A_CAUSE: rdata <= CNT_W'(cause_q);
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign pwr_off     = (state == ST_ENTER) || (state == ST_HIB);
  assign hibernating = (state != ST_IDLE);
endmodule

// File: rtl/hib_ctrl_chk.sv
module hib_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             batt_low,
  input logic             pwr_good,
  input logic             pwr_off,
  input logic             hibernating,
  input logic [CNT_W-1:0] sec_count
);
  logic req_w, load_w;
  assign req_w  = wr_en && addr == 3'd0 && wdata[0] && !hibernating;
  assign load_w = wr_en && addr == 3'd2;

  p_off_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> hibernating);

  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w && !(wdata[3] && batt_low)) |=> pwr_off);

  p_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w && wdata[3] && batt_low) |=> !hibernating);

  p_wake_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_off) |-> hibernating);

  p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hibernating && !pwr_off && !pwr_good) |=> (hibernating && !pwr_off));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_w) && sec_count != $past(sec_count))
      |-> (sec_count == $past(sec_count) + CNT_W'(1)));
endmodule

bind hib_ctrl hib_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .batt_low(batt_low), .pwr_good(pwr_good), .pwr_off(pwr_off),
  .hibernating(hibernating), .sec_count(sec_count)
);

// File: tb/sim_hib_ctrl.sv
module sim_hib_ctrl;
  localparam int W = 32;
  localparam int P = 8;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata, sec_count;
  logic rvalid, wake_pin = 0, batt_low = 0, pwr_good = 1, pwr_off, hibernating;

  int n_chk = 0, n_fail = 0;
  string       exp_tag [$];
  logic [W-1:0] exp_val [$];

  always #4 clk = ~clk;

  hib_ctrl #(.CNT_W(W), .TICKS_PER_SEC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .wake_pin(wake_pin),
    .batt_low(batt_low), .pwr_good(pwr_good), .pwr_off(pwr_off),
    .hibernating(hibernating), .sec_count(sec_count)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_exp(logic [2:0] a, logic [W-1:0] e, string tag);
    exp_tag.push_back(tag); exp_val.push_back(e);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_wake(string tag);
    int k = 0;
    while (pwr_off && k < 200) begin @(negedge clk); k++; end
    check({tag, " wake seen"}, W'(pwr_off), 0);
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_val.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10 unexpected read actual=%0h expected=none", rdata);
      end else begin
        automatic string t = exp_tag.pop_front();
        automatic logic [W-1:0] e = exp_val.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pwr_off", W'(pwr_off), 0);
    check("R1 hibernating", W'(hibernating), 0);
    check("R1 count", sec_count, 0);
    rd_exp(3'd6, 0, "R1 cause");

    wr(3'd0, 32'h6);
    rd_exp(3'd0, 32'h6, "R10 ctrl readback");

    batt_low = 1;
    wr(3'd0, 32'h9);
    check("R3 refused pwr_off", W'(pwr_off), 0);
    check("R3 refused idle", W'(hibernating), 0);
    rd_exp(3'd6, 32'h8, "R3 cause bit3");
    wr(3'd6, 32'h8);
    rd_exp(3'd6, 0, "R7 w1c clear");

    pwr_good = 0;
    wr(3'd0, 32'h1);
    check("R2 pwr_off", W'(pwr_off), 1);
    check("R2 hibernating", W'(hibernating), 1);
    wake_pin = 1;
    repeat (6) @(negedge clk);
    check("R4 pin disabled", W'(pwr_off), 1);
    wake_pin = 0;
    repeat (3) @(negedge clk);
    wr(3'd0, 32'h2);
    wake_pin = 1;
    @(negedge clk); check("R4 sync edge1", W'(pwr_off), 1);
    @(negedge clk); check("R4 sync edge2", W'(pwr_off), 1);
    @(negedge clk); check("R4 wake edge3", W'(pwr_off), 0);
    wake_pin = 0;
    repeat (4) @(negedge clk);
    check("R6 waiting", W'(hibernating), 1);
    check("R6 power on", W'(pwr_off), 0);
    pwr_good = 1;
    @(negedge clk);
    check("R6 back idle", W'(hibernating), 0);
    rd_exp(3'd6, 32'h1, "R4 cause pin");
    wr(3'd6, 32'hF);

    wr(3'd2, 100);
    check("R8 load", sec_count, 100);
    repeat (P - 1) @(negedge clk);
    check("R8 before tick", sec_count, 100);
    @(negedge clk);
    check("R8 tick", sec_count, 101);
    rd_exp(3'd1, 101, "R10 count read");

    wr(3'd3, 103); wr(3'd4, 200);
    wr(3'd2, 100);
    wr(3'd0, 32'h5);
    wait_wake("R5 m0");
    check("R5 m0 count", sec_count, 103);
    rd_exp(3'd6, 32'h2, "R5 cause m0");
    wr(3'd6, 32'hF);

    wr(3'd3, 500); wr(3'd4, 205);
    wr(3'd2, 203);
    wr(3'd0, 32'h5);
    wait_wake("R5 m1");
    check("R5 m1 count", sec_count, 205);
    rd_exp(3'd6, 32'h4, "R5 cause m1");
    wr(3'd0, 32'h0);

    wr(3'd5, 0); wr(3'd2, 0);
    repeat (64 * P) @(negedge clk);
    check("R9 no trim", sec_count, 64);
    wr(3'd5, 1); wr(3'd2, 0);
    repeat (64 * P) @(negedge clk);
    check("R9 long second", sec_count, 63);
    @(negedge clk);
    check("R9 long end", sec_count, 64);
    wr(3'd5, 3); wr(3'd2, 0);
    repeat (64 * P - 2) @(negedge clk);
    check("R9 short before", sec_count, 63);
    @(negedge clk);
    check("R9 short end", sec_count, 64);

    repeat (3) @(negedge clk);
    check("R10 reads drained", W'(exp_val.size()), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule